// File: doc/BRIEF.md
# Serial Byte Transmitter with Clear-to-Send Gating

This block turns bytes written by a host into asynchronous serial frames on a single line. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts sixteen pulses of a sample-rate enable supplied from outside. The host writes into a one-byte holding register. The transmitter copies that byte into its shift register early in the start bit. This frees the holding register for the next byte while the current one is being serialized, so back-to-back frames leave no gap on the line.

Separate enable and disable commands start and stop the transmitter. When the host sets an optional flow-control bit, an active-low clear-to-send input decides whether a new frame may begin. It never interrupts a frame that has already started. Two status outputs guide the host. One reports that the holding register may be written. The other reports that both registers are empty.

A disable that arrives very soon after a byte is written from the idle state cancels that byte before any part of it is committed. A later disable lets the frame already in the shift register finish and drops only the byte still waiting in the holding register.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset the line `txd` is HIGH, `tx_rdy` is 0, `tx_emt` is 1 and the transmitter is disabled.
- R2: A frame is 16 sample enables LOW (start), then the 8 data bits LSB first, 16 enables each, then 16 enables HIGH (stop). The line holds each level from the enable that begins the bit through the enable that begins the next bit.
- R3: In the cycle after an enable command with an empty holding register, `tx_rdy` and `tx_emt` are both 1. In the cycle after a holding-register write while enabled, both are 0.
- R4: While the transmitter is disabled, holding-register writes are ignored and `txd` stays HIGH. A write in the same cycle as the enable command is also ignored.
- R5: A new frame starts on a sample enable when the transmitter is enabled and the holding register is full. The byte moves to the shift register on the third enable counted from the one that starts the frame. `tx_rdy` stays 0 throughout the start bit and rises in the cycle after the enable that ends it.
- R6: With `cts_en` = 1, a frame may start only on an enable at which `cts_n` is LOW. While `cts_n` is HIGH, the line stays HIGH and the byte stays in the holding register.
- R7: With `cts_en` = 1, if `cts_n` goes HIGH while a frame is on the line, that frame finishes. The next frame does not start, so `tx_rdy` and `tx_emt` stay 0, until `cts_n` returns LOW.
- R8: With `cts_en` = 0, the value of `cts_n` has no effect on transmission.
- R9: A disable command issued before the third sample enable of a frame cancels that frame. The line returns HIGH, no data bits are sent, and the holding register is emptied.
- R10: A disable command issued after the transfer lets the frame in the shift register finish. Any byte in the holding register is discarded, and the line then idles HIGH.
- R11: If the holding register is full when a stop bit ends and flow control allows, the next start bit begins on that same enable, leaving no idle gap.
- R12: `tx_emt` is 0 while a frame is on the line or the holding register is full. It is 1 once both are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-rate enable, 16 per bit |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | 8 | Byte to transmit |
| cmd_enable | input | 1 | Enable-transmitter command pulse |
| cmd_disable | input | 1 | Disable-transmitter command pulse (wins over enable) |
| cts_en | input | 1 | 1: clear-to-send gates the start of frames |
| cts_n | input | 1 | Active-low clear-to-send |
| tx_rdy | output | 1 | Holding register may be written |
| tx_emt | output | 1 | Holding and shift registers both empty |
| txd | output | 1 | Serial output line, HIGH when idle |

## Verification
The assertions check three rules on every cycle: the holding register never fills while the transmitter is disabled, a frame never starts from idle while flow control blocks it, and a data bit never ends before its sixteenth enable. They also check that the transfer only ever reads a full holding register and that the idle-and-empty status coincides with a HIGH line. Only the bench's scenarios can show the decoded byte values, the exact length of the start bit, the absence of gaps between frames, and the cycle in which `tx_rdy` rises. The same holds for the split between a cancelled frame and a completed one when a disable lands on either side of the transfer enable.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int OVS_DEF    = 16;
    localparam int DATA_W_DEF = 8;
    localparam int XFER_DEF   = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef struct packed {
        tx_state_e st;
        logic      loaded;
    } eng_ctl_s;

    function automatic logic may_start(input logic en, input logic full,
                                       input logic gate_on, input logic clear_n);
        return en && full && (!gate_on || !clear_n);
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              take,
    output logic              enabled,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    logic              en_q;
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (cmd_disable)     en_q <= 1'b0;
            else if (cmd_enable) en_q <= 1'b1;

            if (cmd_disable) begin
                full_q <= 1'b0;
            end else if (wr_en && en_q) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    assign enabled = en_q;
    assign full    = full_q;
    assign data    = data_q;

    // R4: a disabled transmitter never latches a write
    a_r4_no_fill_disabled: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !cmd_enable) |=> !full_q);

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int OVS       = OVS_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int XFER_TICK = XFER_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              enabled,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              cts_en,
    input  logic              cts_n,
    output logic              take,
    output logic              txd,
    output logic              in_start,
    output logic              idle
);

    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] XFER_CNT = CW'(XFER_TICK - 2);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

    eng_ctl_s          ctl_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              go;
    logic              abort;
    logic              last;

    assign go    = tick && may_start(enabled, hold_full, cts_en, cts_n);
    assign last  = (cnt_q == CNT_LAST);
    assign abort = (ctl_q.st == ST_START) && !ctl_q.loaded && !enabled;
    assign take  = tick && enabled && (ctl_q.st == ST_START) && !ctl_q.loaded
                   && (cnt_q == XFER_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '{st: ST_IDLE, loaded: 1'b0};
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '1;
        end else if (abort) begin
            ctl_q <= '{st: ST_IDLE, loaded: 1'b0};
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
            unique case (ctl_q.st)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (go) ctl_q <= '{st: ST_START, loaded: 1'b0};
                end
                ST_START: begin
                    if (take) begin
                        shift_q      <= hold_data;
                        ctl_q.loaded <= 1'b1;
                    end
                    if (last) begin
                        ctl_q.st <= ST_DATA;
                        bit_q    <= '0;
                    end
                end
                ST_DATA: begin
                    if (last) begin
                        shift_q <= shift_q >> 1;
                        bit_q   <= bit_q + 1'b1;
                        if (bit_q == BIT_LAST) ctl_q.st <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (last) begin
                        ctl_q <= go ? '{st: ST_START, loaded: 1'b0}
                                    : '{st: ST_IDLE,  loaded: 1'b0};
                    end
                end
                default: ctl_q <= '{st: ST_IDLE, loaded: 1'b0};
            endcase
        end
    end

    always_comb begin
        unique case (ctl_q.st)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shift_q[0];
            default:  txd = 1'b1;
        endcase
    end

    assign in_start = (ctl_q.st == ST_START);
    assign idle     = (ctl_q.st == ST_IDLE);

    // R6: blocked flow control keeps an idle transmitter idle
    a_r6_cts_blocks_start: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_IDLE && cts_en && cts_n) |=> ctl_q.st != ST_START);

    // R2: a data bit is not cut short
    a_r2_data_bit_held: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_DATA && !(tick && last)) |=> ctl_q.st == ST_DATA);

    // R5: the transfer reads only a full holding register
    a_r5_take_needs_full: assert property (@(posedge clk) disable iff (rst)
        take |-> hold_full);

endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
    import uart_tx_pkg::*;
#(
    parameter int OVS       = OVS_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int XFER_TICK = XFER_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              cts_en,
    input  logic              cts_n,
    output logic              tx_rdy,
    output logic              tx_emt,
    output logic              txd
);

    logic              enabled;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              in_start;
    logic              idle;

    uart_tx_hold #(.DATA_W(DATA_W)) i_hold (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cmd_enable  (cmd_enable),
        .cmd_disable (cmd_disable),
        .take        (take),
        .enabled     (enabled),
        .full        (hold_full),
        .data        (hold_data)
    );

    uart_tx_engine #(.OVS(OVS), .DATA_W(DATA_W), .XFER_TICK(XFER_TICK)) i_engine (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .enabled   (enabled),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cts_en    (cts_en),
        .cts_n     (cts_n),
        .take      (take),
        .txd       (txd),
        .in_start  (in_start),
        .idle      (idle)
    );

    assign tx_rdy = enabled && !hold_full && !in_start;
    assign tx_emt = idle && !hold_full;

    // R12: an empty transmitter leaves the line at mark
    a_r12_empty_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_emt |-> txd);

endmodule

// File: tb/test_uart_tx_cts.sv
`timescale 1ns/1ps
module test_uart_tx_cts;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cmd_enable = 1'b0;
    logic       cmd_disable = 1'b0;
    logic       cts_en = 1'b0;
    logic       cts_n = 1'b0;
    logic       tx_rdy;
    logic       tx_emt;
    logic       txd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    bit         lq[$];
    logic [7:0] got[$];
    int         starts[$];
    logic [7:0] expq[$];

    always #2 clk = ~clk;

    uart_tx_cts i_uart_tx_cts (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .cts_en(cts_en), .cts_n(cts_n),
        .tx_rdy(tx_rdy), .tx_emt(tx_emt), .txd(txd)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tk(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            lq.push_back(txd);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic en_cmd();
        @(negedge clk) cmd_enable = 1'b1;
        @(negedge clk) cmd_enable = 1'b0;
    endtask

    task automatic dis_cmd();
        @(negedge clk) cmd_disable = 1'b1;
        @(negedge clk) cmd_disable = 1'b0;
    endtask

    task automatic clear_log();
        lq.delete();
        lq.push_back(1'b1);
    endtask

    function automatic int low_count();
        int c = 0;
        foreach (lq[i]) if (!lq[i]) c++;
        return c;
    endfunction

    // frame decoder: mid-bit samples of 16-enable bits
    function automatic void decode();
        got.delete();
        starts.delete();
        for (int i = 1; i + 159 < lq.size(); i++) begin
            if (lq[i-1] && !lq[i]) begin
                if (!lq[i+8] && lq[i+152]) begin
                    logic [7:0] v;
                    for (int b = 0; b < 8; b++) v[b] = lq[i + 16*(b+1) + 8];
                    got.push_back(v);
                    starts.push_back(i);
                    i = i + 158;
                end
            end
        end
    endfunction

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", txd, 1);
        chk("R1 tx_rdy", tx_rdy, 0);
        chk("R1 tx_emt", tx_emt, 1);

        // R4: writes while disabled, and with the enable command, are ignored
        wr(8'h3C);
        chk("R4 emt after ignored write", tx_emt, 1);
        @(negedge clk) begin cmd_enable = 1'b1; wr_en = 1'b1; wr_data = 8'h99; end
        @(negedge clk) begin cmd_enable = 1'b0; wr_en = 1'b0; end
        clear_log();
        tk(40);
        chk("R4 line idle", low_count(), 0);
        // R3 status after enable
        chk("R3 rdy after enable", tx_rdy, 1);
        chk("R3 emt after enable", tx_emt, 1);
        dis_cmd();

        // R3 / R5 timing of tx_rdy
        en_cmd();
        cts_en = 1'b0;
        clear_log();
        wr(8'hA5);
        chk("R3 rdy after write", tx_rdy, 0);
        chk("R3 emt after write", tx_emt, 0);
        tk(16);
        chk("R5 rdy during start", tx_rdy, 0);
        chk("R5 line low in start", txd, 0);
        tk(1);
        chk("R5 rdy after start", tx_rdy, 1);
        chk("R5 first data bit", txd, 1);
        chk("R12 emt in frame", tx_emt, 0);
        tk(160);
        decode();
        chk("R2 frame count A5", got.size(), 1);
        if (got.size() == 1) chk("R2 byte A5", got[0], 8'hA5);
        chk("R12 emt when drained", tx_emt, 1);

        // R8 + R2 start length with flow control off and cts_n high
        cts_en = 1'b0; cts_n = 1'b1;
        clear_log();
        wr(8'hFF);
        tk(200);
        decode();
        chk("R8 frame count", got.size(), 1);
        if (got.size() == 1) begin
            chk("R8 byte", got[0], 8'hFF);
            chk("R2 start last low", lq[starts[0]+15], 0);
            chk("R2 start ends at 16", lq[starts[0]+16], 1);
        end

        // R6 flow control holds the byte
        cts_en = 1'b1; cts_n = 1'b1;
        clear_log();
        wr(8'h0F);
        tk(100);
        chk("R6 line held high", low_count(), 0);
        chk("R6 emt while blocked", tx_emt, 0);
        cts_n = 1'b0;
        tk(200);
        decode();
        chk("R6 frame after release", got.size(), 1);
        if (got.size() == 1) chk("R6 byte", got[0], 8'h0F);

        // R7 flow control stop mid-frame
        clear_log();
        wr(8'h81);
        tk(20);
        wr(8'h42);
        tk(40);
        cts_n = 1'b1;
        tk(300);
        decode();
        chk("R7 only first frame", got.size(), 1);
        if (got.size() == 1) chk("R7 first byte", got[0], 8'h81);
        chk("R7 emt while waiting", tx_emt, 0);
        chk("R7 rdy while waiting", tx_rdy, 0);
        cts_n = 1'b0;
        clear_log();
        tk(200);
        decode();
        chk("R7 second after release", got.size(), 1);
        if (got.size() == 1) chk("R7 second byte", got[0], 8'h42);

        // R9 early disable cancels
        cts_en = 1'b0;
        clear_log();
        wr(8'h5A);
        tk(2);
        dis_cmd();
        @(negedge clk);
        chk("R9 line high after cancel", txd, 1);
        tk(200);
        decode();
        chk("R9 no frame", got.size(), 0);
        en_cmd();
        chk("R9 holding emptied", tx_rdy, 1);

        // R10 late disable finishes frame, drops holding byte
        clear_log();
        wr(8'hC3);
        tk(3);
        wr(8'h77);
        dis_cmd();
        tk(400);
        decode();
        chk("R10 one frame", got.size(), 1);
        if (got.size() == 1) chk("R10 byte", got[0], 8'hC3);
        chk("R10 line idle", txd, 1);
        en_cmd();
        chk("R10 holding dropped", tx_rdy, 1);

        // R2 / R11 random back-to-back stream
        cts_en = 1'($urandom % 2);
        cts_n = 1'b0;
        clear_log();
        expq.delete();
        for (int n = 0; n < 10; n++) begin
            logic [7:0] d;
            while (!tx_rdy) tk(1);
            d = 8'($urandom);
            expq.push_back(d);
            wr(d);
        end
        tk(400);
        decode();
        chk("R2 random frame count", got.size(), expq.size());
        for (int k = 0; k < got.size() && k < expq.size(); k++)
            chk("R2 random byte", got[k], expq[k]);
        for (int k = 0; k + 1 < starts.size(); k++)
            chk("R11 no gap", starts[k+1] - starts[k], 160);
        chk("R12 emt at end", tx_emt, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule